// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block collects the event pulses that a frame-based display controller core raises and keeps each one as a sticky status bit. The core reports five kinds of event: a new frame has begun because its descriptor was loaded into the DMA registers, the DMA transfer count has reached zero at the end of a frame, the lower input FIFO has underrun, the upper input FIFO has underrun, and the frame now leaving the output pins has ended. A graceful-shutdown tracker uses the enable and disable control bits and the frame-end event to set a disable-done status bit. A quick shutdown, made by clearing the enable bit, never sets that bit.

Per-source mask bits decide which status bits can reach one combined, registered interrupt request line. The mask gates only the request. A masked source still records its status, and software can still read and clear it. One mask bit covers both underrun sources. Software reads and writes the block through a small register port. Offset 0 holds status and is read and write-1-to-clear. Offset 1 holds the masks and is read/write. Read data is combinational on the selected offset.

Top module: `disp_irq_status`

## Requirements
- R1: After reset, status reads 0, the mask register reads 0xF (every source masked), and `irq_o` is 0.
- R2: A pulse on `ev_frame_start` sets status bit 0 (start of frame). A pulse on `ev_count_zero` sets status bit 1 (end of frame). Each bit reads 1 from the cycle after the pulse.
- R3: `ev_under_lo` sets status bit 2 and `ev_under_hi` sets status bit 3, independently of each other.
- R4: Status bits stay set until software writes 1 to their position at offset 0. A 0 in the write data leaves that bit unchanged. Status bits 7:5 and mask bits 7:4 read as 0.
- R5: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: The mask register at offset 1 holds write data bits 3:0, and they read back unchanged. Bit 0 masks start of frame, bit 1 masks end of frame, bit 2 masks both underruns, and bit 3 masks disable-done. Writing the masks never changes status, and status bits still set while masked.
- R7: `irq_o` is the OR, over all status bits, of (status AND NOT its mask), taken from the status and masks of the previous cycle (one cycle of latency).
- R8: With mask bit 2 clear, either underrun status bit on its own raises `irq_o`. With mask bit 2 set, neither one does.
- R9: Status bit 4 (disable-done) is set on a frame-end pulse only when a graceful disable was requested by pulsing `ctl_disable` in an earlier cycle while `ctl_enable` was high, and enable has stayed high since then.
- R10: Clearing `ctl_enable` never sets status bit 4. It also cancels a pending graceful-disable request, so a later frame end does not set the bit either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_frame_start | input | 1 | Frame descriptor loaded (start of frame) pulse |
| ev_count_zero | input | 1 | DMA transfer count reached zero (end of frame) pulse |
| ev_under_lo | input | 1 | Lower input FIFO underrun pulse |
| ev_under_hi | input | 1 | Upper input FIFO underrun pulse |
| ev_frame_done | input | 1 | Frame on the output pins has completed pulse |
| ctl_enable | input | 1 | Controller enable bit; low means quick shutdown |
| ctl_disable | input | 1 | Graceful-disable request pulse |
| reg_addr | input | 1 | Register offset: 0 status, 1 masks |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The main sweep goes through all 16 mask values against all 16 combinations of the four event-driven status bits. It compares the read-back status and the registered request against a sum-of-terms formula worked out in the bench. This separates a mask that gates status from one that gates only the request, and it catches a wrong mask-to-source mapping or a shared underrun mask that covers only one FIFO. Partial write-1-to-clear patterns and same-cycle set-and-clear tell a true sticky register from plain overwrite or clear priority. The shutdown sequences cover a graceful request followed by a frame end, a frame end with no request, a request and a frame end in the same cycle, and a quick shutdown before the frame end. Together they separate the proper disable-done path from one that fires on quick shutdown or forgets a cancellation.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned NUM_STAT = 5;
  localparam int unsigned NUM_MASK = 4;

  localparam int unsigned ST_SOF   = 0;
  localparam int unsigned ST_EOF   = 1;
  localparam int unsigned ST_UNDLO = 2;
  localparam int unsigned ST_UNDHI = 3;
  localparam int unsigned ST_DDONE = 4;

  localparam int unsigned MK_SOF   = 0;
  localparam int unsigned MK_EOF   = 1;
  localparam int unsigned MK_UND   = 2;
  localparam int unsigned MK_DDONE = 3;

  typedef enum logic {
    OFS_STATUS = 1'b0,
    OFS_MASK   = 1'b1
  } reg_ofs_e;

  // Spread the mask bits so that each status bit has its own gate;
  // the single underrun mask covers both FIFO underrun bits.
  function automatic logic [NUM_STAT-1:0] spread_mask(input logic [NUM_MASK-1:0] m);
    logic [NUM_STAT-1:0] s;
    s[ST_SOF]   = m[MK_SOF];
    s[ST_EOF]   = m[MK_EOF];
    s[ST_UNDLO] = m[MK_UND];
    s[ST_UNDHI] = m[MK_UND];
    s[ST_DDONE] = m[MK_DDONE];
    return s;
  endfunction

  function automatic logic any_unmasked(input logic [NUM_STAT-1:0] st,
                                        input logic [NUM_MASK-1:0] m);
    return |(st & ~spread_mask(m));
  endfunction
endpackage

// File: rtl/disp_irq_shutdown.sv
module disp_irq_shutdown (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_enable,
  input  logic ctl_disable,
  input  logic ev_frame_done,
  output logic pending_o,
  output logic dd_set_o
);
  logic pend_q;

  // Only a request registered in an earlier cycle can complete.
  assign dd_set_o  = ctl_enable && pend_q && ev_frame_done;
  assign pending_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               pend_q <= 1'b0;
    else if (!ctl_enable)     pend_q <= 1'b0;
    else if (dd_set_o)        pend_q <= 1'b0;
    else if (ctl_disable)     pend_q <= 1'b1;
  end
endmodule

// File: rtl/disp_irq_sticky.sv
module disp_irq_sticky #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] stat_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (set_i[b]) bit_q <= 1'b1;
      else if (clr_i[b]) bit_q <= 1'b0;
    end
    assign stat_o[b] = bit_q;
  end
endmodule

// File: rtl/disp_irq_combine.sv
module disp_irq_combine
  import disp_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_STAT-1:0] stat_i,
  input  logic [NUM_MASK-1:0] mask_i,
  output logic                irq_o
);
  logic irq_q;
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_unmasked(stat_i, mask_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_frame_start,
  input  logic              ev_count_zero,
  input  logic              ev_under_lo,
  input  logic              ev_under_hi,
  input  logic              ev_frame_done,
  input  logic              ctl_enable,
  input  logic              ctl_disable,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int unsigned PAD_ST = DATA_W - NUM_STAT;
  localparam int unsigned PAD_MK = DATA_W - NUM_MASK;

  logic                dd_set;
  logic                dd_pending;
  logic [NUM_STAT-1:0] stat_set;
  logic [NUM_STAT-1:0] stat_clr;
  logic [NUM_STAT-1:0] stat_q;
  logic [NUM_MASK-1:0] mask_q;
  logic                wr_status;
  logic                wr_mask;

  assign wr_status = reg_wr && (reg_addr == OFS_STATUS);
  assign wr_mask   = reg_wr && (reg_addr == OFS_MASK);

  disp_irq_shutdown u_shut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_enable    (ctl_enable),
    .ctl_disable   (ctl_disable),
    .ev_frame_done (ev_frame_done),
    .pending_o     (dd_pending),
    .dd_set_o      (dd_set)
  );

  always_comb begin
    stat_set           = '0;
    stat_set[ST_SOF]   = ev_frame_start;
    stat_set[ST_EOF]   = ev_count_zero;
    stat_set[ST_UNDLO] = ev_under_lo;
    stat_set[ST_UNDHI] = ev_under_hi;
    stat_set[ST_DDONE] = dd_set;
  end

  assign stat_clr = wr_status ? reg_wdata[NUM_STAT-1:0] : '0;

  disp_irq_sticky #(.WIDTH(NUM_STAT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (stat_set),
    .clr_i  (stat_clr),
    .stat_o (stat_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (wr_mask) mask_q <= reg_wdata[NUM_MASK-1:0];
  end

  disp_irq_combine u_comb (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  assign reg_rdata = (reg_addr == OFS_MASK) ? {{PAD_MK{1'b0}}, mask_q}
                                            : {{PAD_ST{1'b0}}, stat_q};
endmodule

// File: rtl/disp_irq_status_chk.sv
module disp_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_frame_start,
  input logic       ev_count_zero,
  input logic       ev_under_lo,
  input logic       ev_under_hi,
  input logic       ev_frame_done,
  input logic       ctl_enable,
  input logic       reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       irq_o,
  input logic [4:0] stat_q,
  input logic [3:0] mask_q,
  input logic       dd_pending
);
  logic req_now;
  logic any_ev;
  logic clr1;
  assign req_now = (stat_q[0] & ~mask_q[0]) | (stat_q[1] & ~mask_q[1]) |
                   ((stat_q[2] | stat_q[3]) & ~mask_q[2]) | (stat_q[4] & ~mask_q[3]);
  assign any_ev  = ev_frame_start | ev_count_zero | ev_under_lo | ev_under_hi | ev_frame_done;
  assign clr1    = reg_wr && !reg_addr && reg_wdata[1];

  assert_sof_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_start |=> stat_q[0]);
  assert_under_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_under_hi |=> stat_q[3]);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1] && !clr1) |=> stat_q[1]);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_count_zero && clr1) |=> stat_q[1]);
  assert_mask_keeps_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !any_ev) |=> $stable(stat_q));
  assert_irq_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(req_now)));
  assert_dd_needs_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[4] && !ev_frame_done) |=> !stat_q[4]);
  assert_no_quick_dd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[4] && !ctl_enable) |=> (!stat_q[4] && !dd_pending));
endmodule

bind disp_irq_status disp_irq_status_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_frame_start (ev_frame_start),
  .ev_count_zero  (ev_count_zero),
  .ev_under_lo    (ev_under_lo),
  .ev_under_hi    (ev_under_hi),
  .ev_frame_done  (ev_frame_done),
  .ctl_enable     (ctl_enable),
  .reg_addr       (reg_addr),
  .reg_wr         (reg_wr),
  .reg_wdata      (reg_wdata),
  .irq_o          (irq_o),
  .stat_q         (stat_q),
  .mask_q         (mask_q),
  .dd_pending     (dd_pending)
);

// File: tb/disp_irq_status_tb.sv
module disp_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_frame_start = 0, ev_count_zero = 0, ev_under_lo = 0, ev_under_hi = 0;
  logic       ev_frame_done = 0, ctl_enable = 0, ctl_disable = 0;
  logic       reg_addr = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disp_irq_status dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_frame_start(ev_frame_start), .ev_count_zero(ev_count_zero),
    .ev_under_lo(ev_under_lo), .ev_under_hi(ev_under_hi),
    .ev_frame_done(ev_frame_done), .ctl_enable(ctl_enable), .ctl_disable(ctl_disable),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Inputs are set a little after an edge; one call captures them at the next edge.
  task automatic tick();
    @(posedge clk); #1;
    ev_frame_start = 0; ev_count_zero = 0; ev_under_lo = 0; ev_under_hi = 0;
    ev_frame_done = 0; ctl_disable = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wr = 1; reg_wdata = d; tick();
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  function automatic logic exp_irq(input logic [4:0] s, input logic [3:0] m);
    int hits = 0;
    if (s[0] && !m[0]) hits++;
    if (s[1] && !m[1]) hits++;
    if ((s[2] || s[3]) && !m[2]) hits++;
    if (s[4] && !m[3]) hits++;
    return hits != 0;
  endfunction

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(0, rv); check("R1 status", rv, 8'h00);
    rd(1, rv); check("R1 mask", rv, 8'h0F);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // Masked sources still record status (R6); sweep masks x patterns (R2 R3 R6 R7 R8).
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        wr(1, 8'(m));
        wr(0, 8'h1F);
        ev_frame_start = s[0]; ev_count_zero = s[1]; ev_under_lo = s[2]; ev_under_hi = s[3];
        tick();
        rd(0, rv); check("R2/R3 status set", rv, 8'(s));
        rd(1, rv); check("R6 mask readback", rv, 8'(m));
        tick();
        check((s[3:2] != 0) ? "R8 underrun irq" : "R7 irq", {7'd0, irq_o},
              {7'd0, exp_irq(5'(s), 4'(m))});
      end
    end

    // R4: partial clear, zero bits left alone.
    wr(1, 8'h0F); wr(0, 8'h1F);
    ev_frame_start = 1; ev_count_zero = 1; ev_under_lo = 1; ev_under_hi = 1; tick();
    wr(0, 8'h05);
    rd(0, rv); check("R4 partial clear", rv, 8'h0A);
    tick(); tick();
    rd(0, rv); check("R4 sticky hold", rv, 8'h0A);
    wr(1, 8'hFF);
    rd(1, rv); check("R4 mask upper zero", rv, 8'h0F);
    rd(0, rv); check("R6 mask write keeps status", rv, 8'h0A);

    // R5: set and clear same cycle.
    ev_count_zero = 1; reg_addr = 0; reg_wr = 1; reg_wdata = 8'h0A; tick();
    rd(0, rv); check("R5 set wins", rv, 8'h02);
    wr(0, 8'h1F);

    // R9: graceful disable then frame end.
    ctl_enable = 1; tick();
    ev_frame_done = 1; tick();
    rd(0, rv); check("R9 no request no ddone", rv, 8'h00);
    ctl_disable = 1; ev_frame_done = 1; tick();
    rd(0, rv); check("R9 same-cycle request not yet", rv, 8'h00);
    tick();
    ev_frame_done = 1; tick();
    rd(0, rv); check("R9 ddone set", rv, 8'h10);
    wr(1, 8'h07); tick();
    check("R7 ddone irq unmasked", {7'd0, irq_o}, 8'h01);
    wr(1, 8'h0F); tick();
    check("R7 ddone irq masked", {7'd0, irq_o}, 8'h00);
    wr(0, 8'h10);
    ev_frame_done = 1; tick();
    rd(0, rv); check("R9 request consumed", rv, 8'h00);

    // R10: quick shutdown.
    ctl_disable = 1; tick();
    ctl_enable = 0; ev_frame_done = 1; tick();
    rd(0, rv); check("R10 quick no ddone", rv, 8'h00);
    ctl_enable = 1; tick();
    ev_frame_done = 1; tick();
    rd(0, rv); check("R10 request cancelled", rv, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule